// File: doc/BRIEF.md
# Serial Divider-Setting Loader for an Integer-N Synthesizer

This block holds the divider settings of a frequency synthesizer and produces them as decoded fields: a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler-bypass flag. It also produces a few control bits: power-down, counter-load and a selection of which internal signal drives the data-out pin. Settings arrive over a slow three-wire serial port (bit clock, data, load strobe) plus a write-enable line that steers the serial stream to a second, 8-bit control register. A parallel mode takes the three divide fields straight from input pins.

All serial lines are brought into the system clock domain through synchronizers, and their edges are detected there. While the steering line is low, each rising bit-clock edge shifts one data bit into a 20-bit holding buffer, and a rising load strobe copies that buffer into the frequency register. While the steering line is high, bits shift into an 8-bit holding buffer instead, and the control register is updated on the falling edge of the steering line. The bit order within the frequency word is interleaved and is unscrambled by the decoder.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, with parallel mode off, every output is zero, and both holding buffers and both registers are zero.
- R2: While `enh_wr` is low, each rising edge of `ser_clk` shifts `ser_data` into the 20-bit frequency buffer so that the first bit sent ends at bit 0. The frequency register takes the buffer on a rising edge of `ser_load`, and at no other time.
- R3: Frequency word layout (bit index: field bit): r_div[5]=0, r_div[4]=1, m_div[8]=2, m_div[7]=3, bypass=4, m_div[6..0]=5..11 (m_div[6] at 5, descending), r_div[3..0]=12..15 (r_div[3] at 12, descending), a_div[3..0]=16..19 (a_div[3] at 16, descending).
- R4: While `enh_wr` is high, each rising edge of `ser_clk` shifts `ser_data` into the 8-bit control buffer, first bit ending at bit 0. The control register takes the buffer on a falling edge of `enh_wr`. Control bit 3 drives `pwr_down` and bit 4 drives `cnt_load`.
- R5: While `enh_n` is high, `pwr_down` and `cnt_load` are 0 and `dout_sel` is 0, whatever the control register holds.
- R6: `dout_sel` encodes 0 for none, 1 for main divider output (control bit 2), 2 for reference divider output (control bit 6) and 3 for modulus select (control bit 5). When more than one is set, the priority is main, then reference, then modulus select.
- R7: With `direct_mode` high, `r_div`, `m_div` and `a_div` follow `dir_r`, `dir_m` and `dir_a`, and `bypass` is 0. With `direct_mode` low, the stored frequency word is decoded again.
- R8: An edge on `ser_load` becomes visible at the outputs on the third rising `clk` edge after the line changes: two synchronizer stages and one register.
- R9: Bits shifted while `enh_wr` is high leave the frequency buffer and the frequency register untouched. A frequency load leaves the control register untouched.
- R10: Control bits 0, 1 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data, first bit lands at bit 0 |
| ser_load | input | 1 | Frequency register load strobe, rising edge |
| enh_wr | input | 1 | Steers the serial stream to the control buffer; falling edge commits it |
| direct_mode | input | 1 | 1 selects parallel divide inputs |
| enh_n | input | 1 | Active-low enable for the control bits |
| dir_r | input | 6 | Parallel reference divide value |
| dir_m | input | 9 | Parallel main divide value |
| dir_a | input | 4 | Parallel swallow count |
| r_div | output | 6 | Reference divide value |
| m_div | output | 9 | Main divide value |
| a_div | output | 4 | Swallow count |
| bypass | output | 1 | Prescaler bypass |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Continuous counter load |
| dout_sel | output | 2 | Data-out source select |

## Verification
On every cycle the assertions check the commit rules: the frequency register changes only after a load-strobe rise and then equals the previous buffer, the control register changes only after a steering-line fall, control-path shifting leaves the frequency buffer alone, bypass stays low in parallel mode, and the control outputs stay off while `enh_n` is high. The interleaved field layout, the first-in-lands-at-bit-0 order, the dout priority, the three-cycle latency and the harmlessness of the reserved bits can only be shown by the bench's scenarios, which compare against a behavioural model driven from delayed pin history.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int FREQ_W = 20;
    localparam int ENH_W  = 8;
    localparam int R_W    = 6;
    localparam int M_W    = 9;
    localparam int A_W    = 4;

    // control-register bit positions
    localparam int EB_FP   = 2;
    localparam int EB_PWR  = 3;
    localparam int EB_LOAD = 4;
    localparam int EB_MSEL = 5;
    localparam int EB_FC   = 6;

    // frequency-word bit carrying the prescaler bypass
    localparam int FB_BYP = 4;

    typedef enum logic [1:0] {
        DOUT_NONE = 2'd0,
        DOUT_FP   = 2'd1,
        DOUT_FC   = 2'd2,
        DOUT_MSEL = 2'd3
    } dout_sel_e;

endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl  = s_q.chain[STAGES-1];
    assign prev = s_q.chain[STAGES];

endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
    import synth_prog_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int EW = ENH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_stb,
    input  logic          to_enh,
    input  logic          bit_in,
    input  logic          freq_stb,
    input  logic          enh_stb,
    output logic [FW-1:0] fbuf,
    output logic [EW-1:0] ebuf,
    output logic [FW-1:0] freq,
    output logic [EW-1:0] enh
);
    typedef struct packed {
        logic [FW-1:0] fbuf;
        logic [EW-1:0] ebuf;
        logic [FW-1:0] freq;
        logic [EW-1:0] enh;
    } reg_st_t;

    reg_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_stb) begin
            if (to_enh) begin
                r_d.ebuf = {bit_in, r_q.ebuf[EW-1:1]};
            end else begin
                r_d.fbuf = {bit_in, r_q.fbuf[FW-1:1]};
            end
        end
        if (freq_stb) begin
            r_d.freq = r_q.fbuf;
        end
        if (enh_stb) begin
            r_d.enh = r_q.ebuf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fbuf = r_q.fbuf;
    assign ebuf = r_q.ebuf;
    assign freq = r_q.freq;
    assign enh  = r_q.enh;

endmodule

// File: rtl/synth_prog_decode.sv
module synth_prog_decode
    import synth_prog_pkg::*;
(
    input  logic [FREQ_W-1:0] freq,
    input  logic [ENH_W-1:0]  enh,
    input  logic              direct_mode,
    input  logic              enh_n,
    input  logic [R_W-1:0]    dir_r,
    input  logic [M_W-1:0]    dir_m,
    input  logic [A_W-1:0]    dir_a,
    output logic [R_W-1:0]    r_div,
    output logic [M_W-1:0]    m_div,
    output logic [A_W-1:0]    a_div,
    output logic              bypass,
    output logic              pwr_down,
    output logic              cnt_load,
    output logic [1:0]        dout_sel
);
    // word position of each field bit, indexed by field bit
    localparam int R_POS [R_W] = '{15, 14, 13, 12, 1, 0};
    localparam int M_POS [M_W] = '{11, 10, 9, 8, 7, 6, 5, 3, 2};
    localparam int A_POS [A_W] = '{19, 18, 17, 16};

    logic [R_W-1:0] ser_r;
    logic [M_W-1:0] ser_m;
    logic [A_W-1:0] ser_a;
    logic           enh_on;
    dout_sel_e      sel;

    always_comb begin
        for (int i = 0; i < R_W; i++) ser_r[i] = freq[R_POS[i]];
        for (int i = 0; i < M_W; i++) ser_m[i] = freq[M_POS[i]];
        for (int i = 0; i < A_W; i++) ser_a[i] = freq[A_POS[i]];
    end

    always_comb begin
        if (direct_mode) begin
            r_div  = dir_r;
            m_div  = dir_m;
            a_div  = dir_a;
            bypass = 1'b0;
        end else begin
            r_div  = ser_r;
            m_div  = ser_m;
            a_div  = ser_a;
            bypass = freq[FB_BYP];
        end
    end

    assign enh_on = !enh_n;

    always_comb begin
        sel = DOUT_NONE;
        if (enh_on) begin
            if (enh[EB_FP])        sel = DOUT_FP;
            else if (enh[EB_FC])   sel = DOUT_FC;
            else if (enh[EB_MSEL]) sel = DOUT_MSEL;
        end
    end

    assign pwr_down = enh_on & enh[EB_PWR];
    assign cnt_load = enh_on & enh[EB_LOAD];
    assign dout_sel = sel;

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           enh_wr,
    input  logic           direct_mode,
    input  logic           enh_n,
    input  logic [R_W-1:0] dir_r,
    input  logic [M_W-1:0] dir_m,
    input  logic [A_W-1:0] dir_a,
    output logic [R_W-1:0] r_div,
    output logic [M_W-1:0] m_div,
    output logic [A_W-1:0] a_div,
    output logic           bypass,
    output logic           pwr_down,
    output logic           cnt_load,
    output logic [1:0]     dout_sel
);
    localparam int NSIG  = 4;
    localparam int I_CLK = 0;
    localparam int I_LD  = 1;
    localparam int I_EWR = 2;
    localparam int I_DAT = 3;

    logic [NSIG-1:0] pins, lvl, prev;
    logic            clk_rise, ld_rise, ewr_fall, ewr_lvl, data_s;
    logic [FREQ_W-1:0] fbuf, freq;
    logic [ENH_W-1:0]  ebuf, enh;

    assign pins = {ser_data, enh_wr, ser_load, ser_clk};

    synth_prog_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins),
        .lvl  (lvl),
        .prev (prev)
    );

    assign clk_rise = lvl[I_CLK] & ~prev[I_CLK];
    assign ld_rise  = lvl[I_LD]  & ~prev[I_LD];
    assign ewr_fall = ~lvl[I_EWR] & prev[I_EWR];
    assign ewr_lvl  = lvl[I_EWR];
    assign data_s   = lvl[I_DAT] | (prev[I_DAT] & 1'b0);

    synth_prog_regs #(.FW(FREQ_W), .EW(ENH_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_stb(clk_rise),
        .to_enh   (ewr_lvl),
        .bit_in   (data_s),
        .freq_stb (ld_rise),
        .enh_stb  (ewr_fall),
        .fbuf     (fbuf),
        .ebuf     (ebuf),
        .freq     (freq),
        .enh      (enh)
    );

    synth_prog_decode dec_i (
        .freq       (freq),
        .enh        (enh),
        .direct_mode(direct_mode),
        .enh_n      (enh_n),
        .dir_r      (dir_r),
        .dir_m      (dir_m),
        .dir_a      (dir_a),
        .r_div      (r_div),
        .m_div      (m_div),
        .a_div      (a_div),
        .bypass     (bypass),
        .pwr_down   (pwr_down),
        .cnt_load   (cnt_load),
        .dout_sel   (dout_sel)
    );

endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        direct_mode,
    input logic        enh_n,
    input logic        clk_rise,
    input logic        ld_rise,
    input logic        ewr_fall,
    input logic        ewr_lvl,
    input logic [19:0] fbuf,
    input logic [19:0] freq,
    input logic [7:0]  enh,
    input logic        bypass,
    input logic        pwr_down,
    input logic        cnt_load,
    input logic [1:0]  dout_sel
);
    p_commit_takes_buffer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rise |=> (freq == $past(fbuf)));

    p_freq_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(freq));

    p_enh_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ewr_fall |=> $stable(enh));

    p_enh_shift_spares_freq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_rise && ewr_lvl) |=> $stable(fbuf));

    p_no_bypass_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |-> !bypass);

    p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> (!pwr_down && !cnt_load && dout_sel == 2'd0));

endmodule

bind synth_prog_if synth_prog_if_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .direct_mode(direct_mode),
    .enh_n      (enh_n),
    .clk_rise   (clk_rise),
    .ld_rise    (ld_rise),
    .ewr_fall   (ewr_fall),
    .ewr_lvl    (ewr_lvl),
    .fbuf       (fbuf),
    .freq       (freq),
    .enh        (enh),
    .bypass     (bypass),
    .pwr_down   (pwr_down),
    .cnt_load   (cnt_load),
    .dout_sel   (dout_sel)
);

// File: tb/synth_prog_if_tb.sv
`timescale 1ns/1ps
module synth_prog_if_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, enh_wr = 1'b0;
    logic direct_mode = 1'b0, enh_n = 1'b0;
    logic [5:0] dir_r = '0;
    logic [8:0] dir_m = '0;
    logic [3:0] dir_a = '0;
    logic [5:0] r_div;
    logic [8:0] m_div;
    logic [3:0] a_div;
    logic bypass, pwr_down, cnt_load;
    logic [1:0] dout_sel;

    always #2.5 clk = ~clk;

    synth_prog_if dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .enh_wr(enh_wr), .direct_mode(direct_mode),
        .enh_n(enh_n), .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a),
        .r_div(r_div), .m_div(m_div), .a_div(a_div), .bypass(bypass),
        .pwr_down(pwr_down), .cnt_load(cnt_load), .dout_sel(dout_sel)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    // ---------------- behavioural reference model ----------------
    typedef struct packed { logic dat; logic ewr; logic ld; logic ck; } pin_t;
    pin_t hist[$];
    logic [19:0] m_fbuf, m_freq;
    logic [7:0]  m_ebuf, m_enh;

    function automatic logic [19:0] encode(input logic [5:0] r, input logic [8:0] m,
                                           input logic [3:0] a, input logic byp);
        logic [19:0] w;
        w = '0;
        w[0] = r[5]; w[1] = r[4]; w[12] = r[3]; w[13] = r[2]; w[14] = r[1]; w[15] = r[0];
        w[2] = m[8]; w[3] = m[7];
        for (int k = 0; k < 7; k++) w[5+k] = m[6-k];
        for (int k = 0; k < 4; k++) w[16+k] = a[3-k];
        w[4] = byp;
        return w;
    endfunction

    always @(posedge clk) begin
        pin_t lv, pv, now;
        now = '{dat: ser_data, ewr: enh_wr, ld: ser_load, ck: ser_clk};
        if (!rst_n) begin
            hist = {pin_t'(0), pin_t'(0), pin_t'(0)};
            m_fbuf = '0; m_freq = '0; m_ebuf = '0; m_enh = '0;
        end else begin
            logic [19:0] nf, nfr;
            logic [7:0]  ne, nen;
            lv = hist[hist.size()-2];
            pv = hist[hist.size()-3];
            nf = m_fbuf; ne = m_ebuf; nfr = m_freq; nen = m_enh;
            if (lv.ck && !pv.ck) begin
                if (lv.ewr) ne = {lv.dat, m_ebuf[7:1]};
                else        nf = {lv.dat, m_fbuf[19:1]};
            end
            if (lv.ld && !pv.ld)   nfr = m_fbuf;
            if (!lv.ewr && pv.ewr) nen = m_ebuf;
            m_fbuf = nf; m_ebuf = ne; m_freq = nfr; m_enh = nen;
            hist.push_back(now);
            void'(hist.pop_front());
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [5:0] er; logic [8:0] em; logic [3:0] ea; logic eb;
            logic [1:0] ed;
            if (direct_mode) begin
                er = dir_r; em = dir_m; ea = dir_a; eb = 1'b0;
            end else begin
                er = {m_freq[0], m_freq[1], m_freq[12], m_freq[13], m_freq[14], m_freq[15]};
                em = {m_freq[2], m_freq[3], m_freq[5], m_freq[6], m_freq[7],
                      m_freq[8], m_freq[9], m_freq[10], m_freq[11]};
                ea = {m_freq[16], m_freq[17], m_freq[18], m_freq[19]};
                eb = m_freq[4];
            end
            ed = 2'd0;
            if (!enh_n) begin
                if (m_enh[2]) ed = 2'd1;
                else if (m_enh[6]) ed = 2'd2;
                else if (m_enh[5]) ed = 2'd3;
            end
            chk(direct_mode ? "R7" : "R3", "model r_div", r_div, er);
            chk(direct_mode ? "R7" : "R3", "model m_div", m_div, em);
            chk(direct_mode ? "R7" : "R3", "model a_div", a_div, ea);
            chk(direct_mode ? "R7" : "R3", "model bypass", bypass, eb);
            chk("R4", "model pwr_down", pwr_down, !enh_n && m_enh[3]);
            chk("R4", "model cnt_load", cnt_load, !enh_n && m_enh[4]);
            chk("R6", "model dout_sel", dout_sel, ed);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic shift_word(input logic [19:0] w, input int n, input logic to_enh);
        enh_wr = to_enh;
        step(3);
        for (int i = 0; i < n; i++) begin
            ser_data = w[i];
            step(2);
            ser_clk = 1'b1;
            step(3);
            ser_clk = 1'b0;
            step(2);
        end
    endtask

    task automatic pulse_load();
        ser_load = 1'b1; step(3); ser_load = 1'b0; step(3);
    endtask

    task automatic write_enh(input logic [7:0] v);
        shift_word({12'd0, v}, 8, 1'b1);
        enh_wr = 1'b0;
        step(4);
    endtask

    task automatic check_fields(input string req, input logic [5:0] r, input logic [8:0] m,
                                input logic [3:0] a, input logic b);
        @(negedge clk);
        chk(req, "r_div", r_div, r);
        chk(req, "m_div", m_div, m);
        chk(req, "a_div", a_div, a);
        chk(req, "bypass", bypass, b);
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] w1, w2, w3;
        w1 = encode(6'h2D, 9'h1A5, 4'hB, 1'b1);
        w2 = encode(6'h12, 9'h0F3, 4'h5, 1'b0);
        w3 = encode(6'h3F, 9'h001, 4'h0, 1'b1);
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1: reset state
        check_fields("R1", 6'd0, 9'd0, 4'd0, 1'b0);
        chk("R1", "pwr_down", pwr_down, 0);
        chk("R1", "cnt_load", cnt_load, 0);
        chk("R1", "dout_sel", dout_sel, 0);
        cmp_on = 1;

        // R2: shifted word not visible before the load strobe
        shift_word(w1, 20, 1'b0);
        step(4);
        check_fields("R2", 6'd0, 9'd0, 4'd0, 1'b0);

        // R8: latency of the load strobe
        @(posedge clk); #1;
        ser_load = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R8", "m_div two edges after strobe", m_div, 0);
        @(negedge clk);
        chk("R8", "m_div three edges after strobe", m_div, 9'h1A5);
        step(2);
        ser_load = 1'b0;
        step(3);
        // R3: field layout, first pattern
        check_fields("R3", 6'h2D, 9'h1A5, 4'hB, 1'b1);

        // R3: second pattern
        shift_word(w2, 20, 1'b0);
        pulse_load();
        check_fields("R3", 6'h12, 9'h0F3, 4'h5, 1'b0);

        // R4: control register commits only on falling enh_wr
        shift_word({12'd0, 8'h08}, 8, 1'b1);
        step(4);
        @(negedge clk);
        chk("R4", "pwr_down before commit", pwr_down, 0);
        enh_wr = 1'b0;
        step(4);
        @(negedge clk);
        chk("R4", "pwr_down after commit", pwr_down, 1);
        // R9: control write left frequency fields alone
        check_fields("R9", 6'h12, 9'h0F3, 4'h5, 1'b0);

        // R5: enable gate
        enh_n = 1'b1;
        step(1);
        @(negedge clk);
        chk("R5", "pwr_down gated", pwr_down, 0);
        enh_n = 1'b0;
        step(1);

        // R6: dout priority
        write_enh(8'h64);
        @(negedge clk);
        chk("R6", "dout all three", dout_sel, 1);
        write_enh(8'h60);
        @(negedge clk);
        chk("R6", "dout fc over msel", dout_sel, 2);
        write_enh(8'h20);
        @(negedge clk);
        chk("R6", "dout msel alone", dout_sel, 3);
        write_enh(8'h10);
        @(negedge clk);
        chk("R4", "cnt_load", cnt_load, 1);
        chk("R6", "dout none", dout_sel, 0);
        enh_n = 1'b1;
        step(1);
        @(negedge clk);
        chk("R5", "cnt_load gated", cnt_load, 0);
        enh_n = 1'b0;

        // R10: reserved control bits ignored
        write_enh(8'h83);
        @(negedge clk);
        chk("R10", "pwr_down", pwr_down, 0);
        chk("R10", "cnt_load", cnt_load, 0);
        chk("R10", "dout_sel", dout_sel, 0);
        check_fields("R10", 6'h12, 9'h0F3, 4'h5, 1'b0);

        // R9: control shifting between frequency shift and load
        shift_word(w3, 20, 1'b0);
        write_enh(8'hFF);
        check_fields("R9", 6'h12, 9'h0F3, 4'h5, 1'b0);
        pulse_load();
        check_fields("R9", 6'h3F, 9'h001, 4'h0, 1'b1);
        write_enh(8'h00);

        // R7: direct mode
        dir_r = 6'h15; dir_m = 9'h0AA; dir_a = 4'h9;
        direct_mode = 1'b1;
        step(1);
        check_fields("R7", 6'h15, 9'h0AA, 4'h9, 1'b0);
        dir_r = 6'h01; dir_m = 9'h1FF; dir_a = 4'hF;
        step(1);
        check_fields("R7", 6'h01, 9'h1FF, 4'hF, 1'b0);
        direct_mode = 1'b0;
        step(1);
        check_fields("R7", 6'h3F, 9'h001, 4'h0, 1'b1);

        step(5);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule